// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block chooses, for a five-stage integer pipeline, where each operand of the instructions in flight should come from. It looks at the instruction sitting in the decode/execute register and the one in the execute/memory register. It compares the registers they read against the registers about to be written by the two older instructions. The older instructions sit in the execute/memory and memory/writeback registers. From these comparisons it produces encoded multiplexer selects and the selected data values.

Three consumers are served. The first is the two ALU operands of the instruction entering execute; the same first operand also drives the branch zero test. The second is the write data of a store that has reached the memory stage. Producers are the ALU result one stage ahead, and the ALU result or loaded data two stages ahead. Stall generation and the register file lie outside the block.

The selects and data are registered. Each output set reflects the pipeline-register contents presented on the previous rising clock edge. A synchronous active-high reset clears every output.

Top module: `bypass_ctrl`

## Requirements
- R1: `a_sel` and `b_sel` use the code 2'b00 = register file or immediate path, 2'b01 = execute/memory ALU result, 2'b10 = memory/writeback result, and never take 2'b11. `opnd_a` and `opnd_b` carry the value named by the select.
- R2: Operation classes are encoded 0 = no-op, 1 = register-register ALU, 2 = register-immediate ALU, 3 = load, 4 = store, 5 = branch-if-zero. The written register is `rd` for class 1 and `rt` for classes 2 and 3. Classes 0, 4 and 5 write nothing and are never a bypass source.
- R3: An instruction in execute/memory is a source only when its class is 1 or 2. A load there never yields select 2'b01.
- R4: When both older stages write the register a consumer reads, the execute/memory value wins (select 2'b01).
- R5: A producer whose destination is register 0 is never forwarded. Reading register 0 gives select 2'b00, and a store of register 0 gives `st_sel` = 0.
- R6: The memory/writeback value is the loaded data for a class 3 producer and the ALU result otherwise.
- R7: Operand B is checked against `rt` only for a class 1 consumer. For every other class, `b_sel` is 2'b00 and `opnd_b` equals the immediate. For class 1 with no match, `opnd_b` equals the register value `de_b`.
- R8: Operand A is checked against `rs` for every class except no-op. A no-op consumer gives `a_sel` = 2'b00.
- R9: For a class 4 instruction in execute/memory, if the memory/writeback producer writes that store's `rt`, then `st_sel` is 1 and `st_wdata` is the memory/writeback value. Otherwise `st_sel` is 0 and `st_wdata` is `em_b`.
- R10: `zero_hit` is 1 exactly when the consumer class is 5 and the bypassed operand A equals zero.
- R11: Outputs update only on the rising clock edge, reflecting the inputs present at that edge. While `rst` is high at an edge, all outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| de_op | input | 3 | Class of instruction in decode/execute register |
| de_rs | input | AW | First source register of that instruction |
| de_rt | input | AW | Second source register of that instruction |
| de_a | input | XLEN | Register-file value for operand A |
| de_b | input | XLEN | Register-file value for operand B |
| de_imm | input | XLEN | Sign-extended immediate |
| em_op | input | 3 | Class of instruction in execute/memory register |
| em_rt | input | AW | Its `rt` field |
| em_rd | input | AW | Its `rd` field |
| em_alu | input | XLEN | Its ALU result |
| em_b | input | XLEN | Its carried store data |
| mw_op | input | 3 | Class of instruction in memory/writeback register |
| mw_rt | input | AW | Its `rt` field |
| mw_rd | input | AW | Its `rd` field |
| mw_alu | input | XLEN | Its ALU result |
| mw_lmd | input | XLEN | Its loaded data |
| a_sel | output | 2 | Operand A select |
| b_sel | output | 2 | Operand B select |
| st_sel | output | 1 | Store data taken from memory/writeback |
| opnd_a | output | XLEN | Selected operand A (also zero-test input) |
| opnd_b | output | XLEN | Selected operand B |
| st_wdata | output | XLEN | Selected store write data |
| zero_hit | output | 1 | Branch zero test result |

## Verification
Some properties are checked against the previous cycle's inputs on every cycle:
- the legal select codes;
- no forwarding from register 0 or to a no-op;
- a non-ALU instruction in execute/memory never being picked;
- the immediate path for non-register-register consumers;
- the store select only for stores;
- a zero flag only with a zero operand.

Which source wins under a double match needs the scenarios. So does the choice between load data and ALU result, the exact destination field used per class, and the one-cycle output timing, including mid-run reset. The bench walks a table of producer/consumer patterns and compares selects and data against values it derives itself.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_RR  = 3'd1,
    OP_RI  = 3'd2,
    OP_LD  = 3'd3,
    OP_ST  = 3'd4,
    OP_BZ  = 3'd5
  } opc_e;

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_EXM = 2'b01;
  localparam logic [1:0] SEL_MWB = 2'b10;
endpackage

// File: rtl/bypass_dest.sv
module bypass_dest
  import bypass_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [2:0]    op,
  input  logic [AW-1:0] rt,
  input  logic [AW-1:0] rd,
  output logic [AW-1:0] dst,
  output logic          dst_ok,
  output logic          from_alu
);
  logic writes;

  always_comb begin
    dst      = '0;
    writes   = 1'b0;
    from_alu = 1'b0;
    case (opc_e'(op))
      OP_RR: begin dst = rd; writes = 1'b1; from_alu = 1'b1; end
      OP_RI: begin dst = rt; writes = 1'b1; from_alu = 1'b1; end
      OP_LD: begin dst = rt; writes = 1'b1; end
      default: ;
    endcase
  end

  assign dst_ok = writes && (dst != '0);
endmodule

// File: rtl/bypass_pick.sv
module bypass_pick
  import bypass_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          need,
  input  logic [AW-1:0] src,
  input  logic          ex_ok,
  input  logic [AW-1:0] ex_dst,
  input  logic          mw_ok,
  input  logic [AW-1:0] mw_dst,
  output logic [1:0]    sel
);
  always_comb begin
    sel = SEL_RF;
    if (need) begin
      if (ex_ok && ex_dst == src)      sel = SEL_EXM;
      else if (mw_ok && mw_dst == src) sel = SEL_MWB;
    end
  end
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl
  import bypass_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      de_op,
  input  logic [AW-1:0]   de_rs,
  input  logic [AW-1:0]   de_rt,
  input  logic [XLEN-1:0] de_a,
  input  logic [XLEN-1:0] de_b,
  input  logic [XLEN-1:0] de_imm,
  input  logic [2:0]      em_op,
  input  logic [AW-1:0]   em_rt,
  input  logic [AW-1:0]   em_rd,
  input  logic [XLEN-1:0] em_alu,
  input  logic [XLEN-1:0] em_b,
  input  logic [2:0]      mw_op,
  input  logic [AW-1:0]   mw_rt,
  input  logic [AW-1:0]   mw_rd,
  input  logic [XLEN-1:0] mw_alu,
  input  logic [XLEN-1:0] mw_lmd,
  output logic [1:0]      a_sel,
  output logic [1:0]      b_sel,
  output logic            st_sel,
  output logic [XLEN-1:0] opnd_a,
  output logic [XLEN-1:0] opnd_b,
  output logic [XLEN-1:0] st_wdata,
  output logic            zero_hit
);
  localparam int NOPND = 2;

  logic [AW-1:0]   em_dst, mw_dst;
  logic            em_dok, mw_dok, em_alu_src, mw_alu_src;
  logic            em_ok;
  logic [XLEN-1:0] mw_val;

  bypass_dest #(.AW(AW)) u_em_dest (
    .op(em_op), .rt(em_rt), .rd(em_rd),
    .dst(em_dst), .dst_ok(em_dok), .from_alu(em_alu_src)
  );

  bypass_dest #(.AW(AW)) u_mw_dest (
    .op(mw_op), .rt(mw_rt), .rd(mw_rd),
    .dst(mw_dst), .dst_ok(mw_dok), .from_alu(mw_alu_src)
  );

  // a load one stage ahead has no data yet; only ALU results leave that stage
  assign em_ok  = em_dok && em_alu_src;
  assign mw_val = mw_alu_src ? mw_alu : mw_lmd;

  logic [AW-1:0] src  [NOPND];
  logic          need [NOPND];
  logic [1:0]    sel_c[NOPND];

  assign src[0]  = de_rs;
  assign src[1]  = de_rt;
  assign need[0] = (opc_e'(de_op) != OP_NOP);
  assign need[1] = (opc_e'(de_op) == OP_RR);

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    bypass_pick #(.AW(AW)) u_pick (
      .need(need[g]), .src(src[g]),
      .ex_ok(em_ok), .ex_dst(em_dst),
      .mw_ok(mw_dok), .mw_dst(mw_dst),
      .sel(sel_c[g])
    );
  end

  function automatic logic [XLEN-1:0] mux3(input logic [1:0] s,
                                           input logic [XLEN-1:0] rf,
                                           input logic [XLEN-1:0] ex,
                                           input logic [XLEN-1:0] mw);
    case (s)
      SEL_EXM: return ex;
      SEL_MWB: return mw;
      default: return rf;
    endcase
  endfunction

  logic [XLEN-1:0] b_base, a_val, b_val, st_val;
  logic            st_c, zero_c;

  assign b_base = (opc_e'(de_op) == OP_RR) ? de_b : de_imm;
  assign a_val  = mux3(sel_c[0], de_a, em_alu, mw_val);
  assign b_val  = mux3(sel_c[1], b_base, em_alu, mw_val);
  assign st_c   = (opc_e'(em_op) == OP_ST) && mw_dok && (mw_dst == em_rt);
  assign st_val = st_c ? mw_val : em_b;
  assign zero_c = (opc_e'(de_op) == OP_BZ) && (a_val == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sel    <= SEL_RF;
      b_sel    <= SEL_RF;
      st_sel   <= 1'b0;
      opnd_a   <= '0;
      opnd_b   <= '0;
      st_wdata <= '0;
      zero_hit <= 1'b0;
    end else begin
      a_sel    <= sel_c[0];
      b_sel    <= sel_c[1];
      st_sel   <= st_c;
      opnd_a   <= a_val;
      opnd_b   <= b_val;
      st_wdata <= st_val;
      zero_hit <= zero_c;
    end
  end
endmodule

// File: rtl/bypass_ctrl_chk.sv
module bypass_ctrl_chk
  import bypass_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      de_op,
  input logic [AW-1:0]   de_rs,
  input logic [XLEN-1:0] de_imm,
  input logic [2:0]      em_op,
  input logic [1:0]      a_sel,
  input logic [1:0]      b_sel,
  input logic            st_sel,
  input logic [XLEN-1:0] opnd_a,
  input logic [XLEN-1:0] opnd_b,
  input logic            zero_hit
);
  p_sel_code_r1: assert property (@(posedge clk) disable iff (rst)
    (a_sel != 2'b11) && (b_sel != 2'b11));

  p_ex_alu_only_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(em_op) != OP_RR && $past(em_op) != OP_RI)
      |-> (a_sel != SEL_EXM && b_sel != SEL_EXM));

  p_no_reg0_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(de_rs) == '0) |-> a_sel == SEL_RF);

  p_imm_path_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(de_op) != OP_RR)
      |-> (b_sel == SEL_RF && opnd_b == $past(de_imm)));

  p_nop_a_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(de_op) == OP_NOP) |-> a_sel == SEL_RF);

  p_store_only_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && st_sel) |-> $past(em_op) == OP_ST);

  p_zero_val_r10: assert property (@(posedge clk) disable iff (rst)
    zero_hit |-> opnd_a == '0);
endmodule

bind bypass_ctrl bypass_ctrl_chk #(.XLEN(XLEN), .AW(AW)) u_chk (.*);

// File: tb/bypass_ctrl_tb.sv
module bypass_ctrl_tb;
  localparam int XLEN = 32;
  localparam int AW   = 5;

  localparam logic [XLEN-1:0] CA  = 32'hA0A0_0011;
  localparam logic [XLEN-1:0] CB  = 32'hB0B0_0022;
  localparam logic [XLEN-1:0] CI  = 32'hC0C0_0033;
  localparam logic [XLEN-1:0] CEA = 32'hE0E0_0044;
  localparam logic [XLEN-1:0] CEB = 32'hE1E1_0055;
  localparam logic [XLEN-1:0] CMA = 32'hF0F0_0066;
  localparam logic [XLEN-1:0] CML = 32'hF1F1_0077;

  typedef struct packed {
    logic [2:0] id_op; logic [4:0] id_rs; logic [4:0] id_rt;
    logic [2:0] ex_op; logic [4:0] ex_rt; logic [4:0] ex_rd;
    logic [2:0] mw_op; logic [4:0] mw_rt; logic [4:0] mw_rd;
    logic [1:0] ea; logic [1:0] eb; logic es;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 5'd1, 5'd2, 3'd1, 5'd0, 5'd1, 3'd1, 5'd0, 5'd2, 2'b01, 2'b10, 1'b0}, // R1 both sources
    '{3'd1, 5'd3, 5'd3, 3'd2, 5'd3, 5'd0, 3'd3, 5'd3, 5'd0, 2'b01, 2'b01, 1'b0}, // R4 newer wins
    '{3'd1, 5'd3, 5'd4, 3'd3, 5'd3, 5'd0, 3'd1, 5'd0, 5'd9, 2'b00, 2'b00, 1'b0}, // R3 load ahead
    '{3'd2, 5'd5, 5'd5, 3'd1, 5'd0, 5'd7, 3'd3, 5'd5, 5'd0, 2'b10, 2'b00, 1'b0}, // R6 load data, R7 imm
    '{3'd1, 5'd0, 5'd0, 3'd1, 5'd0, 5'd0, 3'd1, 5'd0, 5'd0, 2'b00, 2'b00, 1'b0}, // R5 reg 0
    '{3'd0, 5'd1, 5'd1, 3'd1, 5'd0, 5'd1, 3'd1, 5'd0, 5'd1, 2'b00, 2'b00, 1'b0}, // R8 no-op consumer
    '{3'd1, 5'd6, 5'd6, 3'd4, 5'd6, 5'd6, 3'd5, 5'd6, 5'd6, 2'b00, 2'b00, 1'b0}, // R2 store/branch no dest
    '{3'd1, 5'd8, 5'd9, 3'd1, 5'd8, 5'd10, 3'd2, 5'd9, 5'd8, 2'b00, 2'b10, 1'b0}, // R2 rd vs rt
    '{3'd0, 5'd0, 5'd0, 3'd4, 5'd4, 5'd0, 3'd3, 5'd4, 5'd0, 2'b00, 2'b00, 1'b1}, // R9 load->store
    '{3'd0, 5'd0, 5'd0, 3'd4, 5'd4, 5'd0, 3'd1, 5'd0, 5'd4, 2'b00, 2'b00, 1'b1}, // R9 alu->store
    '{3'd0, 5'd0, 5'd0, 3'd4, 5'd4, 5'd0, 3'd4, 5'd4, 5'd0, 2'b00, 2'b00, 1'b0}, // R9 store no source
    '{3'd0, 5'd0, 5'd0, 3'd4, 5'd0, 5'd0, 3'd3, 5'd0, 5'd0, 2'b00, 2'b00, 1'b0}, // R5 store of reg 0
    '{3'd4, 5'd2, 5'd3, 3'd1, 5'd0, 5'd2, 3'd1, 5'd0, 5'd3, 2'b01, 2'b00, 1'b0}, // R7 store consumer
    '{3'd5, 5'd7, 5'd0, 3'd0, 5'd0, 5'd0, 3'd2, 5'd7, 5'd0, 2'b10, 2'b00, 1'b0}  // R10 branch operand
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [2:0]      de_op = '0, em_op = '0, mw_op = '0;
  logic [AW-1:0]   de_rs = '0, de_rt = '0, em_rt = '0, em_rd = '0, mw_rt = '0, mw_rd = '0;
  logic [XLEN-1:0] de_a = CA, de_b = CB, de_imm = CI, em_alu = CEA, em_b = CEB;
  logic [XLEN-1:0] mw_alu = CMA, mw_lmd = CML;
  logic [1:0]      a_sel, b_sel;
  logic            st_sel, zero_hit;
  logic [XLEN-1:0] opnd_a, opnd_b, st_wdata;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bypass_ctrl #(.XLEN(XLEN), .AW(AW)) u_dut (.*);

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    de_op = v.id_op; de_rs = v.id_rs; de_rt = v.id_rt;
    em_op = v.ex_op; em_rt = v.ex_rt; em_rd = v.ex_rd;
    mw_op = v.mw_op; mw_rt = v.mw_rt; mw_rd = v.mw_rd;
  endtask

  function automatic logic [XLEN-1:0] pick(input logic [1:0] s, input logic [XLEN-1:0] base,
                                           input logic [2:0] mop);
    logic [XLEN-1:0] mv;
    mv = (mop == 3'd3) ? CML : CMA;
    if (s == 2'b01) return CEA;
    if (s == 2'b10) return mv;
    return base;
  endfunction

  initial begin
    apply(VECS[0]);
    repeat (3) @(negedge clk);
    // R11: reset holds every output at 0 despite matching inputs
    chk("R11 reset a_sel", {30'd0, a_sel}, 32'd0);
    chk("R11 reset b_sel", {30'd0, b_sel}, 32'd0);
    chk("R11 reset opnd_a", opnd_a, 32'd0);
    chk("R11 reset st_wdata", st_wdata, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [XLEN-1:0] bb, ea_v;
      v = VECS[i];
      @(negedge clk);
      apply(v);
      @(negedge clk);
      // R1 R2 R3 R4 R5 R6 R7 R8 R9: selects and data per table row
      chk($sformatf("R1 a_sel vec %0d", i), {30'd0, a_sel}, {30'd0, v.ea});
      chk($sformatf("R7 b_sel vec %0d", i), {30'd0, b_sel}, {30'd0, v.eb});
      chk($sformatf("R9 st_sel vec %0d", i), {31'd0, st_sel}, {31'd0, v.es});
      ea_v = pick(v.ea, CA, v.mw_op);
      bb   = (v.id_op == 3'd1) ? CB : CI;
      chk($sformatf("R6 opnd_a vec %0d", i), opnd_a, ea_v);
      chk($sformatf("R7 opnd_b vec %0d", i), opnd_b, pick(v.eb, bb, v.mw_op));
      chk($sformatf("R9 st_wdata vec %0d", i), st_wdata,
          v.es ? ((v.mw_op == 3'd3) ? CML : CMA) : CEB);
      chk($sformatf("R10 zero_hit vec %0d", i), {31'd0, zero_hit},
          {31'd0, (v.id_op == 3'd5) && (ea_v == '0)});
    end

    // R11: new inputs do not reach the outputs before the clock edge
    @(negedge clk);
    apply(VECS[0]);
    #2;
    chk("R11 hold a_sel", {30'd0, a_sel}, 32'd2);
    @(negedge clk);
    chk("R11 update a_sel", {30'd0, a_sel}, 32'd1);

    // R10: zero test on a bypassed zero
    em_alu = '0;
    apply('{3'd5, 5'd1, 5'd0, 3'd1, 5'd0, 5'd1, 3'd0, 5'd0, 5'd0, 2'b00, 2'b00, 1'b0});
    @(negedge clk);
    chk("R10 bz bypassed zero", {31'd0, zero_hit}, 32'd1);
    chk("R10 bz opnd_a", opnd_a, 32'd0);
    de_op = 3'd1;
    @(negedge clk);
    chk("R10 non-branch zero", {31'd0, zero_hit}, 32'd0);
    em_alu = CEA;
    de_op = 3'd5; de_rs = 5'd2; de_a = '0;
    @(negedge clk);
    chk("R10 bz register zero", {31'd0, zero_hit}, 32'd1);
    de_a = 32'd5;
    @(negedge clk);
    chk("R10 bz nonzero", {31'd0, zero_hit}, 32'd0);
    de_a = CA;

    // R11: reset in mid-run clears outputs
    apply(VECS[8]);
    @(negedge clk);
    chk("R9 st_sel before reset", {31'd0, st_sel}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk("R11 midrun st_sel", {31'd0, st_sel}, 32'd0);
    chk("R11 midrun st_wdata", st_wdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 after reset st_sel", {31'd0, st_sel}, 32'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule